// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block connects an A side and a B side through a parameterised number of byte lanes. By default there are two lanes of 8 data bits and 1 parity bit on each side. All lanes share one set of controls. Each side captures its own bus input into a latch that covers the data and the parity bits. The latch passes the live bus straight through while its enable is high. While the enable is low, the latch presents the value it held at the last clock edge at which the enable was high. A synchronous reset clears both latches to zero.

The active-low output enables choose which side is driven, and the driven side shows the contents of the opposite side's latch. The outgoing parity bit comes from one of two sources, picked by a forward-select input. It is either generated from the latched data, in the even or odd sense chosen by a sense-select input, or it is the latched incoming parity bit passed on unchanged. Each side has an active-low error output for every lane. That output checks the side's latch contents continuously, including while neither bus is driven. If both output enables are low, the block drives neither bus and raises a configuration fault flag.

Bidirectional pins appear as separate input, output and output-enable ports. Each output-enable port covers a whole side. An output reads zero whenever its side is not driven.

Top module: `latched_parity_xcvr`

## Requirements
- R1: While `le_a` (or `le_b`) is high, that side's latch view equals its live bus input in the same cycle, with no clock delay.
- R2: While `le_a` (or `le_b`) is low, that side's latch view equals the input sampled at the last rising clock edge at which the enable was high.
- R3: With `oe_b_n`=0 and `oe_a_n`=1, `b_oe`=1 and `b_dat_o` shows the A latch view. With `oe_a_n`=0 and `oe_b_n`=1, `a_oe`=1 and `a_dat_o` shows the B latch view. When a side is not driven, its `*_oe` is 0 and its data and parity outputs are zero.
- R4: With both output enables low, neither side is driven and `cfg_fault`=1. In every other combination `cfg_fault`=0.
- R5: With `fwd_par`=0, the parity output of lane L is generated from data bits [8L+7:8L] of the source latch view. With the input-side latch closed, those data bits are the held ones.
- R6: With `fwd_par`=1, the parity output of lane L is bit L of the source latch's parity view, passed on unchanged.
- R7: With `odd_sel`=0, generated parity equals the XOR of the 8 data bits, giving an even count of ones over 9 bits. With `odd_sel`=1, it is the inverse of that XOR, giving an odd count.
- R8: `err_a_n[L]` and `err_b_n[L]` are 0 exactly when the count of ones over that side's lane-L latch view (8 data bits plus parity bit) does not match the selected sense. This holds for every output-enable setting, including both buses undriven.
- R9: After synchronous reset with the latch enables low, both latch views read zero. Each error output is then 1 with even sense and 0 with odd sense.
- R10: Lanes are independent: lane L's parity output and error outputs depend only on lane L's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch hold registers |
| rst | input | 1 | Synchronous reset, active high |
| le_a | input | 1 | A latch enable, transparent when high |
| le_b | input | 1 | B latch enable, transparent when high |
| oe_a_n | input | 1 | Active-low enable to drive the A bus |
| oe_b_n | input | 1 | Active-low enable to drive the B bus |
| fwd_par | input | 1 | 1 forwards latched parity, 0 generates it |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| a_dat_i | input | LANES*LANE_W | A bus data input |
| a_par_i | input | LANES | A bus parity input, one per lane |
| b_dat_i | input | LANES*LANE_W | B bus data input |
| b_par_i | input | LANES | B bus parity input, one per lane |
| a_dat_o | output | LANES*LANE_W | A bus data output |
| a_par_o | output | LANES | A bus parity output |
| a_oe | output | 1 | A bus driven |
| b_dat_o | output | LANES*LANE_W | B bus data output |
| b_par_o | output | LANES | B bus parity output |
| b_oe | output | 1 | B bus driven |
| err_a_n | output | LANES | A latch parity error per lane, active low |
| err_b_n | output | LANES | B latch parity error per lane, active low |
| cfg_fault | output | 1 | Both output enables low |

## Verification
The bench closes a latch and then changes the bus under it. A latch that stayed transparent would let the new value reach the far side's outputs and the error flags. It drives both output enables low, where a design that preferred one direction would drive a bus with `cfg_fault` silent. It also runs with both buses undriven and deliberately bad parity, where a checker gated by the output enables would keep the error high. Finally, it flips `odd_sel` and `fwd_par` independently of the data and corrupts one lane at a time. These steps expose an inverted sense, a swapped parity mux, or lanes whose parity bits cross over.

// File: rtl/latched_parity_xcvr.sv
module latched_parity_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    le_a,
  input  logic                    le_b,
  input  logic                    oe_a_n,
  input  logic                    oe_b_n,
  input  logic                    fwd_par,
  input  logic                    odd_sel,
  input  logic [LANES*LANE_W-1:0] a_dat_i,
  input  logic [LANES-1:0]        a_par_i,
  input  logic [LANES*LANE_W-1:0] b_dat_i,
  input  logic [LANES-1:0]        b_par_i,
  output logic [LANES*LANE_W-1:0] a_dat_o,
  output logic [LANES-1:0]        a_par_o,
  output logic                    a_oe,
  output logic [LANES*LANE_W-1:0] b_dat_o,
  output logic [LANES-1:0]        b_par_o,
  output logic                    b_oe,
  output logic [LANES-1:0]        err_a_n,
  output logic [LANES-1:0]        err_b_n,
  output logic                    cfg_fault
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    hold_a_d, hold_b_d, view_a_d, view_b_d;
  logic [LANES-1:0] hold_a_p, hold_b_p, view_a_p, view_b_p;
  logic [LANES-1:0] out_b_p, out_a_p;
  logic             drive_ab, drive_ba;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a_d <= '0;
      hold_a_p <= '0;
      hold_b_d <= '0;
      hold_b_p <= '0;
    end else begin
      if (le_a) begin
        hold_a_d <= a_dat_i;
        hold_a_p <= a_par_i;
      end
      if (le_b) begin
        hold_b_d <= b_dat_i;
        hold_b_p <= b_par_i;
      end
    end
  end

  assign view_a_d = le_a ? a_dat_i : hold_a_d;
  assign view_a_p = le_a ? a_par_i : hold_a_p;
  assign view_b_d = le_b ? b_dat_i : hold_b_d;
  assign view_b_p = le_b ? b_par_i : hold_b_p;

  assign cfg_fault = !oe_a_n && !oe_b_n;
  assign drive_ab  = !oe_b_n && oe_a_n;
  assign drive_ba  = !oe_a_n && oe_b_n;
  assign b_oe      = drive_ab;
  assign a_oe      = drive_ba;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic gen_from_a, gen_from_b;
    assign gen_from_a = (^view_a_d[l*LANE_W +: LANE_W]) ^ odd_sel;
    assign gen_from_b = (^view_b_d[l*LANE_W +: LANE_W]) ^ odd_sel;
    assign out_b_p[l] = fwd_par ? view_a_p[l] : gen_from_a;
    assign out_a_p[l] = fwd_par ? view_b_p[l] : gen_from_b;
    assign err_a_n[l] = ~((^view_a_d[l*LANE_W +: LANE_W]) ^ view_a_p[l] ^ odd_sel);
    assign err_b_n[l] = ~((^view_b_d[l*LANE_W +: LANE_W]) ^ view_b_p[l] ^ odd_sel);

    AST_GEN_SENSE_B: assert property (@(posedge clk) disable iff (rst)
      (b_oe && !fwd_par) |-> ((^b_dat_o[l*LANE_W +: LANE_W]) ^ b_par_o[l]) == odd_sel); // R7
    AST_GEN_SENSE_A: assert property (@(posedge clk) disable iff (rst)
      (a_oe && !fwd_par) |-> ((^a_dat_o[l*LANE_W +: LANE_W]) ^ a_par_o[l]) == odd_sel); // R5
  end

  assign b_dat_o = drive_ab ? view_a_d : '0;
  assign b_par_o = drive_ab ? out_b_p  : '0;
  assign a_dat_o = drive_ba ? view_b_d : '0;
  assign a_par_o = drive_ba ? out_a_p  : '0;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe)); // R3
  AST_FAULT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cfg_fault |-> (!a_oe && !b_oe && b_dat_o == '0 && a_dat_o == '0)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!le_a && $past(!le_a) && $past(!rst) && b_oe && $past(b_oe)) |-> $stable(b_dat_o)); // R2
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !le_a && b_oe) |-> b_dat_o == '0); // R9
endmodule

// File: tb/latched_parity_xcvr_test.sv
module latched_parity_xcvr_test;
  localparam int PERIOD = 10;
  localparam int LANES = 2;
  localparam int LW = 8;
  localparam int DW = LANES * LW;

  logic clk = 0, rst = 1;
  logic le_a = 0, le_b = 0, oe_a_n = 1, oe_b_n = 1, fwd_par = 0, odd_sel = 0;
  logic [DW-1:0] a_dat_i = '0, b_dat_i = '0;
  logic [LANES-1:0] a_par_i = '0, b_par_i = '0;
  logic [DW-1:0] a_dat_o, b_dat_o;
  logic [LANES-1:0] a_par_o, b_par_o, err_a_n, err_b_n;
  logic a_oe, b_oe, cfg_fault;

  int checks = 0, fails = 0;
  logic [DW-1:0] ma_d = '0, mb_d = '0;
  logic [LANES-1:0] ma_p = '0, mb_p = '0;

  latched_parity_xcvr #(.LANES(LANES), .LANE_W(LW)) uut (
    .clk, .rst, .le_a, .le_b, .oe_a_n, .oe_b_n, .fwd_par, .odd_sel,
    .a_dat_i, .a_par_i, .b_dat_i, .b_par_i,
    .a_dat_o, .a_par_o, .a_oe, .b_dat_o, .b_par_o, .b_oe,
    .err_a_n, .err_b_n, .cfg_fault);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [LANES-1:0] gen_par(logic [DW-1:0] d, logic odd);
    for (int l = 0; l < LANES; l++) gen_par[l] = (^d[l*LW +: LW]) ^ odd;
  endfunction

  function automatic logic [LANES-1:0] err_vec(logic [DW-1:0] d, logic [LANES-1:0] p, logic odd);
    for (int l = 0; l < LANES; l++) err_vec[l] = ((^d[l*LW +: LW]) ^ p[l]) == odd;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] va_d, vb_d;
    logic [LANES-1:0] va_p, vb_p;
    logic ab, ba;
    va_d = le_a ? a_dat_i : ma_d;  va_p = le_a ? a_par_i : ma_p;
    vb_d = le_b ? b_dat_i : mb_d;  vb_p = le_b ? b_par_i : mb_p;
    ab = !oe_b_n && oe_a_n;
    ba = !oe_a_n && oe_b_n;
    check({tag, " R3 b_oe"}, 32'(b_oe), 32'(ab));
    check({tag, " R3 a_oe"}, 32'(a_oe), 32'(ba));
    check({tag, " R4 cfg_fault"}, 32'(cfg_fault), 32'(!oe_a_n && !oe_b_n));
    check({tag, " R1 R2 b_dat_o"}, 32'(b_dat_o), ab ? 32'(va_d) : 0);
    check({tag, " R1 R2 a_dat_o"}, 32'(a_dat_o), ba ? 32'(vb_d) : 0);
    check({tag, " R5 R6 R7 R10 b_par_o"}, 32'(b_par_o),
          ab ? 32'(fwd_par ? va_p : gen_par(va_d, odd_sel)) : 0);
    check({tag, " R5 R6 R7 R10 a_par_o"}, 32'(a_par_o),
          ba ? 32'(fwd_par ? vb_p : gen_par(vb_d, odd_sel)) : 0);
    check({tag, " R8 err_a_n"}, 32'(err_a_n), 32'(err_vec(va_d, va_p, odd_sel)));
    check({tag, " R8 err_b_n"}, 32'(err_b_n), 32'(err_vec(vb_d, vb_p, odd_sel)));
  endtask

  task automatic step(string tag);
    #1 check_all(tag);
    @(posedge clk);
    if (rst) begin ma_d = '0; ma_p = '0; mb_d = '0; mb_p = '0; end
    else begin
      if (le_a) begin ma_d = a_dat_i; ma_p = a_par_i; end
      if (le_b) begin mb_d = b_dat_i; mb_p = b_par_i; end
    end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    @(negedge clk);
    a_dat_i = 16'hBEEF; b_dat_i = 16'h1234; a_par_i = 2'b11; b_par_i = 2'b01;
    le_a = 1; le_b = 1;
    step("reset");
    rst = 0; le_a = 0; le_b = 0;
    // R9: cleared latches, even then odd sense
    oe_b_n = 0; odd_sel = 0; step("R9 even");
    odd_sel = 1; step("R9 odd");
    oe_b_n = 1; oe_a_n = 0; step("R9 b2a");
    // R1 then R2: capture, close, change bus
    oe_a_n = 1; oe_b_n = 0; odd_sel = 0; le_a = 1;
    a_dat_i = 16'h00FF; a_par_i = 2'b10; step("R1 open");
    le_a = 0; a_dat_i = 16'hFF01; a_par_i = 2'b01; step("R2 closed");
    fwd_par = 1; step("R6 fwd held");
    // R4 both enables low
    oe_a_n = 0; oe_b_n = 0; step("R4 both low");
    // R8 undriven with bad parity, single lane corrupt (R10)
    oe_a_n = 1; oe_b_n = 1; le_a = 1; le_b = 1; fwd_par = 0;
    a_dat_i = 16'h0100; a_par_i = 2'b00; b_dat_i = 16'h0001; b_par_i = 2'b01;
    step("R8 R10 hiz");
    odd_sel = 1; step("R8 hiz odd");
    for (int i = 0; i < 3000; i++) begin
      rst = ($urandom % 97) == 0;
      le_a = $urandom; le_b = $urandom;
      oe_a_n = $urandom; oe_b_n = $urandom;
      fwd_par = $urandom; odd_sel = $urandom;
      a_dat_i = DW'($urandom); b_dat_i = DW'($urandom);
      a_par_i = LANES'($urandom); b_par_i = LANES'($urandom);
      step("random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule